// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous static RAM with a flow-through read path. Each word is split into byte lanes that can be written one at a time. Every control except output enable and sleep is captured on the rising clock edge. A cycle starts when either of two start strobes is seen while the device is selected. The host strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls.

Once a cycle has started, a step input moves the two low address bits through a four-beat sequence. The sequence is either a plain wrap-around count or an XOR pattern based on the start value. The upper address bits stay fixed for the whole burst. A read returns the addressed word in the same cycle in which its address was captured, with no output register. A burst therefore delivers its first word after two cycles and each later word one cycle apart, and a new random address can be taken on every edge.

The data bus is shared between reads and writes. The block drives it only for a selected read while output enable is active and sleep is low. Sleep is asynchronous: it floats the bus, causes edges to be ignored, and keeps both the stored words and the burst position.

Top module: `burst_sram_ft`

## Requirements
- R1: On a rising edge where `host_start_n` is low (with `cs0_n` low) or `ctrl_start_n` is low, and the device is selected, `addr` is loaded. If both strobes are low, the host strobe takes precedence.
- R2: `host_start_n` is ignored while `cs0_n` is high. A cycle started by the host strobe is always a read, whatever the write controls are.
- R3: In a cycle with no effective start strobe after a selected start, `step_n` low advances the two low address bits by one beat and `step_n` high holds them. The upper bits never change within a burst.
- R4: With `seq_linear` = 1, the low two bits of beat k are (start + k) mod 4.
- R5: With `seq_linear` = 0, the default, the low two bits of beat k are start XOR k.
- R6: `wr_all_n` low writes every lane of the current address, whatever `lane_gate_n` and `lane_wr_n` are.
- R7: With `wr_all_n` high and `lane_gate_n` low, only lanes whose `lane_wr_n` bit is low are written. Bit i controls data bits [9i+8:9i]. With both `wr_all_n` and `lane_gate_n` high, the cycle is a read.
- R8: A start strobe with any chip enable inactive deselects the device: it writes nothing and leaves the bus floating. Selection needs `cs0_n`=0, `cs1`=1 and `cs2_n`=0.
- R9: Flow-through read: the word at the address captured on an edge appears on `dq` in the cycle that follows that edge.
- R10: `dq` is driven only in a selected read cycle while `out_en_n` is low and `doze` is low. `out_en_n` acts without waiting for a clock edge.
- R11: While `doze` is high, edges perform no write and leave the burst state unchanged, and stored words are kept.
- R12: Write data is taken from `dq` on the same edge as the write controls. A burst-continue cycle with write controls writes the stepped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the cycle state |
| addr | input | ADDR_W | Word address |
| cs0_n | input | 1 | Chip enable, active low; also gates the host strobe |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| host_start_n | input | 1 | Host start strobe, read-only cycle start |
| ctrl_start_n | input | 1 | Controller start strobe, read or write |
| step_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| lane_gate_n | input | 1 | Enables the per-lane selects, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| seq_linear | input | 1 | 1 = wrap-around count, 0 = XOR order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous sleep, active high |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench drives four-beat bursts from a non-zero start value in both orders, including the wrap past beat three. A counter that confused the two orders, or that carried into the upper bits, would return the wrong word. It applies a host strobe with the write controls active and a host strobe with `cs0_n` high; a design that wrote, or that restarted the burst, would corrupt the stored word or change the read address. Further cases cover a partial-lane write, a global write with every lane select inactive, a write to a deselected device, and writes attempted during sleep. Each is followed by a read-back that would expose a stray or missing write. Output enable and sleep are toggled between edges to show that the bus floats at once.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
    localparam int BURST_W = 2;
    typedef logic [BURST_W-1:0] beat_t;
endpackage

// File: rtl/bsf_lane_decode.sv
module bsf_lane_decode #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask
);
    always_comb begin
        if (!wr_all_n)
            lane_mask = '1;
        else if (!lane_gate_n)
            lane_mask = ~lane_wr_n;
        else
            lane_mask = '0;
    end
endmodule

// File: rtl/bsf_burst_step.sv
module bsf_burst_step
    import bsf_pkg::*;
(
    input  beat_t start,
    input  beat_t idx,
    input  logic  linear,
    output beat_t idx_nx,
    output beat_t low_nx
);
    always_comb begin
        idx_nx = idx + beat_t'(1);
        if (linear)
            low_nx = start + idx_nx;
        else
            low_nx = start ^ idx_nx;
    end
endmodule

// File: rtl/bsf_array.sv
module bsf_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we_mask[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft
    import bsf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    host_start_n,
    input  logic                    ctrl_start_n,
    input  logic                    step_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    lane_gate_n,
    input  logic                    wr_all_n,
    input  logic                    seq_linear,
    input  logic                    out_en_n,
    input  logic                    doze,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - BURST_W;

    typedef struct packed {
        logic            active;
        logic            rd;
        logic [HI_W-1:0] hi;
        beat_t           start;
        beat_t           idx;
        beat_t           low;
    } cyc_t;

    cyc_t st_d, st_q;

    logic             selected;
    logic             host_go;
    logic             ctrl_go;
    logic             wr_en;
    logic             wr_any;
    logic             drv_en;
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] wr_mask;
    beat_t            idx_nx;
    beat_t            low_nx;
    logic [DATA_W-1:0] rdata;

    assign selected = !cs0_n && cs1 && !cs2_n;
    assign host_go  = !host_start_n && !cs0_n;
    assign ctrl_go  = !ctrl_start_n;
    assign wr_any   = |lane_mask;

    bsf_lane_decode #(.LANES(LANES)) u_decode (
        .wr_all_n    (wr_all_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .lane_mask   (lane_mask)
    );

    bsf_burst_step u_step (
        .start  (st_q.start),
        .idx    (st_q.idx),
        .linear (seq_linear),
        .idx_nx (idx_nx),
        .low_nx (low_nx)
    );

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (!doze) begin
            if (host_go || ctrl_go) begin
                if (selected) begin
                    st_d.active = 1'b1;
                    st_d.hi     = addr[ADDR_W-1:BURST_W];
                    st_d.start  = addr[BURST_W-1:0];
                    st_d.idx    = '0;
                    st_d.low    = addr[BURST_W-1:0];
                    wr_en       = !host_go && wr_any;
                    st_d.rd     = !(!host_go && wr_any);
                end else begin
                    st_d.active = 1'b0;
                    st_d.rd     = 1'b0;
                end
            end else if (st_q.active) begin
                if (!step_n) begin
                    st_d.idx = idx_nx;
                    st_d.low = low_nx;
                end
                wr_en   = wr_any;
                st_d.rd = !wr_any;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_mask = wr_en ? lane_mask : '0;

    bsf_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we_mask (wr_mask),
        .waddr   ({st_d.hi, st_d.low}),
        .wdata   (dq),
        .raddr   ({st_q.hi, st_q.low}),
        .rdata   (rdata)
    );

    assign drv_en = st_q.active && st_q.rd && !out_en_n && !doze;
    assign dq     = drv_en ? rdata : {DATA_W{1'bz}};
endmodule

module bsf_checker
    import bsf_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  doze,
    input logic  host_start_n,
    input logic  ctrl_start_n,
    input logic  cs0_n,
    input logic  cs1,
    input logic  cs2_n,
    input logic  step_n,
    input logic  seq_linear,
    input logic  active_q,
    input beat_t low_q,
    input beat_t start_q,
    input logic  wr_en,
    input logic  drv_en
);
    // R2: host strobe with cs0_n high cannot start a cycle
    p_host_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !host_start_n && cs0_n && ctrl_start_n && !active_q) |=> !active_q);

    // R2: host-started cycle never writes
    p_host_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !host_start_n && !cs0_n) |-> !wr_en);

    // R4: linear advance increments low bits
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && active_q && host_start_n && ctrl_start_n && !step_n && seq_linear)
        |=> low_q == beat_t'($past(low_q) + beat_t'(1)));

    // R5: XOR advance increments the beat index recovered from the address
    p_xor_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && active_q && host_start_n && ctrl_start_n && !step_n && !seq_linear)
        |=> (low_q ^ start_q) == beat_t'($past(low_q ^ start_q) + beat_t'(1)));

    // R8: a start strobe while not selected leaves the device inactive
    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !ctrl_start_n && !(!cs0_n && cs1 && !cs2_n)) |=> !active_q);

    // R10: the cycle after a write never drives the bus
    p_write_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !drv_en);

    // R11: sleep holds burst state
    p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> $stable(low_q) && $stable(active_q));
endmodule

bind burst_sram_ft bsf_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .doze         (doze),
    .host_start_n (host_start_n),
    .ctrl_start_n (ctrl_start_n),
    .cs0_n        (cs0_n),
    .cs1          (cs1),
    .cs2_n        (cs2_n),
    .step_n       (step_n),
    .seq_linear   (seq_linear),
    .active_q     (st_q.active),
    .low_q        (st_q.low),
    .start_q      (st_q.start),
    .wr_en        (wr_en),
    .drv_en       (drv_en)
);

// File: tb/burst_sram_ft_bench.sv
module burst_sram_ft_bench;
    localparam int AW = 6;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic cs0_n, cs1, cs2_n, host_n, ctrl_n, step_n, gate_n, all_n, lin, oe_n, doze;
    logic [1:0] lane_n;
    logic tb_oe;
    logic [DW-1:0] tb_data;
    wire  [DW-1:0] dq;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] m [64];

    assign dq = tb_oe ? tb_data : {DW{1'bz}};
    always #4 clk = ~clk;

    burst_sram_ft u_burst_sram_ft (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .host_start_n(host_n), .ctrl_start_n(ctrl_n), .step_n(step_n), .lane_wr_n(lane_n),
        .lane_gate_n(gate_n), .wr_all_n(all_n), .seq_linear(lin), .out_en_n(oe_n),
        .doze(doze), .dq(dq)
    );

    task automatic chk_dq(input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (dq !== exp) begin
            n_err++;
            $display("FAIL %s: dq=%h expected=%h", tag, dq, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk);
        cs0_n = 0; cs1 = 1; cs2_n = 0; host_n = 1; ctrl_n = 1; step_n = 1;
        lane_n = '1; gate_n = 1; all_n = 1; oe_n = 0; tb_oe = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        prep(); ctrl_n = 0; addr = a; all_n = 0; tb_oe = 1; tb_data = d; oe_n = 1;
        tick(); m[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        prep(); host_n = 0; addr = a; tick();
    endtask

    task automatic cont(input logic adv);
        prep(); step_n = !adv; tick();
    endtask

    task automatic t_reset();
        rst_n = 0; doze = 0; lin = 0; addr = '0; tb_data = '0;
        prep(); tick(); tick();
        prep(); rst_n = 1; tick();
        chk_dq({DW{1'bz}}, "R10 bus floats after reset");
    endtask

    task automatic t_single();
        wr(6'd1, 18'h2A5A5);
        wr(6'd2, 18'h15A5A);
        rd(6'd1); chk_dq(m[1], "R9 flow-through read addr 1");
        rd(6'd2); chk_dq(m[2], "R1 back-to-back new address");
        prep(); ctrl_n = 0; addr = 6'd1; tick();
        chk_dq(m[1], "R7 ctrl strobe without write controls reads");
    endtask

    task automatic t_burst_linear();
        for (int i = 4; i < 8; i++) wr(AW'(i), DW'(18'h01000 + i * 18'h00111));
        lin = 1;
        rd(6'd5); chk_dq(m[5], "R4 linear beat 0");
        cont(1); chk_dq(m[6], "R4 linear beat 1");
        cont(1); chk_dq(m[7], "R4 linear beat 2");
        cont(1); chk_dq(m[4], "R4 linear beat 3 wrap");
        cont(0); chk_dq(m[4], "R3 step_n high holds address");
        cont(1); chk_dq(m[5], "R3 fourth advance returns to start");
    endtask

    task automatic t_burst_xor();
        lin = 0;
        rd(6'd5); chk_dq(m[5], "R5 xor beat 0");
        cont(1); chk_dq(m[4], "R5 xor beat 1");
        cont(1); chk_dq(m[7], "R5 xor beat 2");
        cont(1); chk_dq(m[6], "R5 xor beat 3");
        lin = 1;
    endtask

    task automatic t_global();
        wr(6'd9, 18'h00000);
        prep(); ctrl_n = 0; addr = 6'd9; all_n = 0; gate_n = 0; lane_n = 2'b11;
        tb_oe = 1; tb_data = 18'h3FFFF; oe_n = 1; tick(); m[9] = 18'h3FFFF;
        rd(6'd9); chk_dq(m[9], "R6 global write covers all lanes");
    endtask

    task automatic t_lanes();
        wr(6'd10, 18'h12345);
        prep(); ctrl_n = 0; addr = 6'd10; gate_n = 0; lane_n = 2'b01;
        tb_oe = 1; tb_data = 18'h3FFFF; oe_n = 1; tick();
        m[10] = {9'h1FF, m[10][8:0]};
        rd(6'd10); chk_dq(m[10], "R7 only upper lane written");
        prep(); ctrl_n = 0; addr = 6'd10; lane_n = 2'b00; tick();
        chk_dq(m[10], "R7 lane selects without gate give a read");
    endtask

    task automatic t_host_rules();
        prep(); host_n = 0; addr = 6'd10; all_n = 0; tick();
        chk_dq(m[10], "R2 host strobe with write controls reads");
        prep(); host_n = 0; cs0_n = 1; addr = 6'd20; tick();
        chk_dq(m[10], "R2 host strobe ignored while cs0_n high");
        rd(6'd10); chk_dq(m[10], "R2 no write from host cycle");
    endtask

    task automatic t_deselect();
        prep(); cs1 = 0; ctrl_n = 0; addr = 6'd10; all_n = 0;
        tb_oe = 1; tb_data = 18'h00077; oe_n = 1; tick();
        prep(); tick();
        chk_dq({DW{1'bz}}, "R8 deselected bus floats");
        rd(6'd10); chk_dq(m[10], "R8 deselected write dropped");
        prep(); cs2_n = 1; host_n = 0; addr = 6'd10; tick();
        chk_dq({DW{1'bz}}, "R8 cs2_n high deselects host start");
    endtask

    task automatic t_oe_async();
        rd(6'd4); chk_dq(m[4], "R10 read drives bus");
        oe_n = 1; #1;
        chk_dq({DW{1'bz}}, "R10 out_en_n high floats bus without clock");
        oe_n = 0; #1;
        chk_dq(m[4], "R10 out_en_n low drives again");
    endtask

    task automatic t_sleep();
        rd(6'd6); chk_dq(m[6], "R11 read before sleep");
        doze = 1; #1;
        chk_dq({DW{1'bz}}, "R10 sleep floats bus");
        for (int i = 0; i < 2; i++) begin
            prep(); doze = 1; ctrl_n = 0; addr = 6'd6; all_n = 0;
            tb_oe = 1; tb_data = 18'h3C3C3; oe_n = 1; tick();
        end
        prep(); doze = 0; tick();
        chk_dq(m[6], "R11 state and contents kept through sleep");
    endtask

    task automatic t_burst_write();
        wr(6'd12, 18'h0AAAA);
        prep(); step_n = 0; all_n = 0; tb_oe = 1; tb_data = 18'h05555; oe_n = 1;
        tick(); m[13] = 18'h05555;
        rd(6'd12); chk_dq(m[12], "R12 start write stored");
        rd(6'd13); chk_dq(m[13], "R12 continue write to stepped address");
    endtask

    initial begin
        t_reset();
        t_single();
        t_burst_linear();
        t_burst_xor();
        t_global();
        t_lanes();
        t_host_rules();
        t_deselect();
        t_oe_async();
        t_sleep();
        t_burst_write();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule